// File: doc/BRIEF.md
# Channel Sweep Sequencer with FIFO Trigger

This block decides which analog input an external converter samples next and when the host is told that results are waiting. A command pulse starts one of four run modes. Single mode makes one conversion on the selected channel. Repeat mode keeps converting that channel. Sweep mode makes one pass through a fixed channel pattern. Loop mode repeats that pass. For every conversion the block raises a one-cycle request carrying a channel number, then waits for the converter's done pulse and stores the returned result in an 8-entry FIFO. The host reads the FIFO through a simple pop port.

A two-bit trigger code sets a FIFO level L. That level fixes both the number of conversions in a sweep pass (L+1) and the point at which the interrupt fires. One open-drain-style, active-low pin serves as either an interrupt line or a conversion-busy strobe. With the default of 8 channels, the pattern codes give the orders listed in R4. With NUM_CH = 4, codes 00 and 01 both give 0,1,2,3,0,1,2,3, code 10 gives 0,0,1,1,2,2,3,3 and code 11 gives 0,1,0,1,…

Top module: `chan_sweep_ctrl`

## Requirements
- R1: After reset, pin_n is 1, conv_req is 0 and rd_level is 0.
- R2: In mode 00, a command produces exactly one request, on cfg_chan, and the pattern field has no effect. The result is stored and no further request follows.
- R3: In mode 01, requests on cfg_chan continue until the FIFO holds 8 entries. No request is made while the FIFO is full, and requests resume after a pop.
- R4: In modes 10 and 11, request i of a pass uses the pattern code. Code 00 gives 0,1,2,3,4,5,6,7. Code 01 gives 0,2,4,6,0,2,4,6. Code 10 gives 0,0,2,2,4,4,6,6. Code 11 gives 0,2,0,2,0,2,0,2. A pass has L+1 requests, where L is 7, 5, 3 or 1 for trigger codes 00, 01, 10 and 11.
- R5: In mode 10, exactly one pass is made, and then requests stop.
- R6: In mode 11, a new pass starts only once the FIFO is empty.
- R7: rd_data shows the oldest stored result. rd_pop removes it. rd_level counts the stored results. A pop on an empty FIFO changes nothing.
- R8: With cfg_pin_eoc = 0, pin_n goes low after a result is stored at position L. Position means the number of entries ahead of it once any pop in that same cycle is taken into account. pin_n returns high after the pop that empties the FIFO.
- R9: With cfg_pin_eoc = 1, pin_n goes low at the clock edge that accepts a request. It returns high at the edge that stores that conversion's result.
- R10: conv_diff is 1 alongside each request when cfg_pdiff is 1, and 0 when it is 0.
- R11: cmd_start empties the FIFO, clears the interrupt and restarts the selected mode at pattern step 0.
- R12: A conv_done pulse while no conversion is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Run mode: 00 single, 01 repeat, 10 sweep, 11 loop |
| cfg_pattern | input | 2 | Sweep pattern code |
| cfg_trig | input | 2 | Trigger level code |
| cfg_chan | input | CH_W | Channel for modes 00 and 01 |
| cfg_pin_eoc | input | 1 | 1: pin is busy strobe, 0: pin is interrupt |
| cfg_pdiff | input | 1 | Pseudo-differential input enable |
| cmd_start | input | 1 | Start pulse for a new command |
| conv_req | output | 1 | One-cycle conversion request |
| conv_chan | output | CH_W | Channel for the request |
| conv_diff | output | 1 | Pseudo-differential flag for the request |
| conv_done | input | 1 | Converter result valid pulse |
| conv_data | input | DATA_W | Converter result |
| rd_pop | input | 1 | Remove the oldest FIFO entry |
| rd_data | output | DATA_W | Oldest FIFO entry |
| rd_level | output | CNT_W | Number of stored entries |
| pin_n | output | 1 | Active-low interrupt or busy pin |

## Verification
The FIFO store of a returning result and a host pop can land in the same clock cycle. That changes both the position the new entry takes and whether the interrupt fires. The bench waits for the second done pulse of a two-step sweep and asserts rd_pop in the same half cycle, so the write and the pop share one edge. It then expects one entry left, holding the second result, and pin_n still high, because the entry landed at position 0 rather than 1. A companion vector with no pop shows the interrupt does fire in that same sweep.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

    typedef enum logic [1:0] {
        MODE_ONE    = 2'b00,
        MODE_REPEAT = 2'b01,
        MODE_SWEEP  = 2'b10,
        MODE_LOOP   = 2'b11
    } run_mode_e;

endpackage

// File: rtl/sweep_pattern.sv
module sweep_pattern #(
    parameter int NUM_CH = 8,
    parameter int IDX_W  = 3,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic [1:0]       pattern,
    input  logic [IDX_W-1:0] idx,
    output logic [CH_W-1:0]  chan
);

    generate
        if (NUM_CH == 8) begin : g_wide
            always_comb begin
                unique case (pattern)
                    2'b00:   chan = idx[2:0];
                    2'b01:   chan = {idx[1:0], 1'b0};
                    2'b10:   chan = {idx[2:1], 1'b0};
                    default: chan = {1'b0, idx[0], 1'b0};
                endcase
            end
        end else begin : g_narrow
            always_comb begin
                unique case (pattern)
                    2'b10:   chan = CH_W'(idx[2:1]);
                    2'b11:   chan = CH_W'(idx[0]);
                    default: chan = CH_W'(idx[1:0]);
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/sweep_fifo.sv
module sweep_fifo #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 10,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic              pop_ok,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  count
);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } fifo_state_t;

    fifo_state_t f_d, f_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic push_ok;

    always_comb begin
        f_d     = f_q;
        pop_ok  = pop && (f_q.cnt != '0);
        push_ok = push && ((f_q.cnt < CNT_W'(DEPTH)) || pop_ok) && !flush;
        if (push_ok) begin
            f_d.wp = (f_q.wp == PTR_W'(DEPTH - 1)) ? '0 : f_q.wp + 1'b1;
        end
        if (pop_ok) begin
            f_d.rp = (f_q.rp == PTR_W'(DEPTH - 1)) ? '0 : f_q.rp + 1'b1;
        end
        f_d.cnt = f_q.cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
        if (flush) begin
            f_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[f_q.wp] <= wdata;
    end

    assign rdata = mem[f_q.rp];
    assign count = f_q.cnt;

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop_ok && !flush |-> f_q.cnt < CNT_W'(DEPTH));

    // R7
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop && (f_q.cnt == '0) && !push && !flush |=> f_q.cnt == '0);

endmodule

// File: rtl/chan_sweep_ctrl.sv
module chan_sweep_ctrl
    import sweep_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 10,
    parameter int DEPTH  = 8,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [1:0]        cfg_pattern,
    input  logic [1:0]        cfg_trig,
    input  logic [CH_W-1:0]   cfg_chan,
    input  logic              cfg_pin_eoc,
    input  logic              cfg_pdiff,
    input  logic              cmd_start,
    output logic              conv_req,
    output logic [CH_W-1:0]   conv_chan,
    output logic              conv_diff,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  rd_level,
    output logic              pin_n
);

    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic             active;
        logic             busy;
        logic             irq;
        logic [IDX_W-1:0] idx;
    } seq_state_t;

    seq_state_t s_d, s_q;
    run_mode_e  mode;
    logic [CNT_W-1:0] fifo_count, trig_lvl, wr_level;
    logic [CH_W-1:0]  pat_chan;
    logic go, done_ok, pop_ok, last_idx;

    assign mode     = run_mode_e'(cfg_mode);
    assign trig_lvl = CNT_W'(DEPTH - 1) - CNT_W'({cfg_trig, 1'b0});
    assign done_ok  = conv_done && s_q.busy;
    assign wr_level = fifo_count - CNT_W'(pop_ok);
    assign last_idx = (CNT_W'(s_q.idx) == trig_lvl);

    sweep_pattern #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_pattern (
        .pattern (cfg_pattern),
        .idx     (s_q.idx),
        .chan    (pat_chan)
    );

    sweep_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (cmd_start),
        .push   (done_ok),
        .wdata  (conv_data),
        .pop    (rd_pop),
        .pop_ok (pop_ok),
        .rdata  (rd_data),
        .count  (fifo_count)
    );

    always_comb begin
        s_d = s_q;
        go  = 1'b0;
        if (s_q.active && !s_q.busy) begin
            unique case (mode)
                MODE_REPEAT: go = (fifo_count < CNT_W'(DEPTH));
                MODE_LOOP:   go = (s_q.idx != '0) || (fifo_count == '0);
                default:     go = 1'b1;
            endcase
        end
        if (go) begin
            s_d.busy = 1'b1;
        end
        if (done_ok) begin
            s_d.busy = 1'b0;
            unique case (mode)
                MODE_ONE:    s_d.active = 1'b0;
                MODE_REPEAT: begin end
                default: begin
                    if (last_idx) begin
                        s_d.idx = '0;
                        if (mode == MODE_SWEEP) s_d.active = 1'b0;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            endcase
            if (wr_level == trig_lvl) s_d.irq = 1'b1;
        end else if (pop_ok && (fifo_count == CNT_W'(1))) begin
            s_d.irq = 1'b0;
        end
        if (cmd_start) begin
            s_d        = '0;
            s_d.active = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign conv_req  = go;
    assign conv_chan = cfg_mode[1] ? pat_chan : cfg_chan;
    assign conv_diff = go && cfg_pdiff;
    assign rd_level  = fifo_count;
    assign pin_n     = cfg_pin_eoc ? !s_q.busy : !s_q.irq;

    // R2
    one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req && !cmd_start |=> !conv_req);

    // R9
    eoc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req && cfg_pin_eoc && !cmd_start |=> !pin_n || !cfg_pin_eoc);

    // R5
    sweep_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_ok && (mode == MODE_SWEEP) && last_idx && !cmd_start |=> !conv_req);

endmodule

// File: tb/chan_sweep_ctrl_test.sv
module chan_sweep_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int CH_W  = 3;
    localparam int W     = 10;
    localparam int CNT_W = 4;

    typedef struct packed {
        logic [1:0]  mode;
        logic [1:0]  pat;
        logic [1:0]  trig;
        logic [2:0]  chan;
        logic [3:0]  n;
        logic [31:0] seq;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'b10, 2'b00, 2'b00, 3'd0, 4'd8, 32'h01234567},
        '{2'b10, 2'b01, 2'b00, 3'd0, 4'd8, 32'h02460246},
        '{2'b10, 2'b10, 2'b00, 3'd0, 4'd8, 32'h00224466},
        '{2'b10, 2'b11, 2'b00, 3'd0, 4'd8, 32'h02020202},
        '{2'b10, 2'b00, 2'b01, 3'd0, 4'd6, 32'h01234500},
        '{2'b10, 2'b10, 2'b10, 3'd0, 4'd4, 32'h00220000},
        '{2'b10, 2'b01, 2'b11, 3'd0, 4'd2, 32'h02000000},
        '{2'b00, 2'b11, 2'b00, 3'd5, 4'd1, 32'h50000000},
        '{2'b00, 2'b10, 2'b11, 3'd7, 4'd1, 32'h70000000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [1:0] cfg_mode = '0, cfg_pattern = '0, cfg_trig = '0;
    logic [CH_W-1:0] cfg_chan = '0;
    logic cfg_pin_eoc = 1'b0, cfg_pdiff = 1'b0, cmd_start = 1'b0, rd_pop = 1'b0;
    logic conv_done_m = 1'b0, spur = 1'b0, conv_done;
    logic [W-1:0] conv_data = '0;
    logic conv_req, conv_diff, pin_n;
    logic [CH_W-1:0] conv_chan;
    logic [W-1:0] rd_data;
    logic [CNT_W-1:0] rd_level;

    assign conv_done = conv_done_m | spur;

    chan_sweep_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_pattern(cfg_pattern),
        .cfg_trig(cfg_trig), .cfg_chan(cfg_chan), .cfg_pin_eoc(cfg_pin_eoc),
        .cfg_pdiff(cfg_pdiff), .cmd_start(cmd_start), .conv_req(conv_req),
        .conv_chan(conv_chan), .conv_diff(conv_diff), .conv_done(conv_done),
        .conv_data(conv_data), .rd_pop(rd_pop), .rd_data(rd_data),
        .rd_level(rd_level), .pin_n(pin_n)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    int n_req = 0, n_dat = 0, delay = 0;
    int req_base = 0, dat_base = 0;
    logic [CH_W-1:0] chan_log [256];
    logic            diff_log [256];
    logic [W-1:0]    dat_log  [256];

    // converter model: result three cycles after a request
    always @(negedge clk) begin
        conv_done_m <= 1'b0;
        if (conv_req) begin
            chan_log[n_req % 256] = conv_chan;
            diff_log[n_req % 256] = conv_diff;
            n_req++;
            delay = 3;
        end else if (delay > 0) begin
            delay--;
            if (delay == 0) begin
                dat_log[n_dat % 256] = W'(32'h100 + n_dat);
                conv_done_m <= 1'b1;
                conv_data   <= W'(32'h100 + n_dat);
                n_dat++;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual %0d expected %0d", cyc, 100000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic start_cmd(input logic [1:0] m, input logic [1:0] p, input logic [1:0] t,
                             input logic [2:0] c, input logic eoc, input logic pd);
        @(negedge clk);
        cfg_mode = m; cfg_pattern = p; cfg_trig = t; cfg_chan = c;
        cfg_pin_eoc = eoc; cfg_pdiff = pd;
        req_base = n_req; dat_base = n_dat;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic pop_one(output logic [W-1:0] d);
        @(negedge clk);
        d = rd_data;
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    initial begin
        logic [W-1:0] d;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(pin_n == 1'b1, "R1 pin_n", int'(pin_n), 1);
        chk(conv_req == 1'b0, "R1 conv_req", int'(conv_req), 0);
        chk(rd_level == '0, "R1 rd_level", int'(rd_level), 0);
        rst_n = 1'b1;

        // table of sequences (R2, R4, R5, R7, R8)
        for (int v = 0; v < NV; v++) begin
            start_cmd(VECS[v].mode, VECS[v].pat, VECS[v].trig, VECS[v].chan, 1'b0, 1'b0);
            repeat (50) @(negedge clk);
            chk(n_req - req_base == int'(VECS[v].n), VECS[v].mode[1] ? "R5 pass length" : "R2 one request",
                n_req - req_base, int'(VECS[v].n));
            for (int i = 0; i < int'(VECS[v].n); i++) begin
                chk(chan_log[(req_base + i) % 256] == VECS[v].seq[4*(7-i) +: 3],
                    VECS[v].mode[1] ? "R4 channel" : "R2 channel",
                    int'(chan_log[(req_base + i) % 256]), int'(VECS[v].seq[4*(7-i) +: 3]));
            end
            chk(rd_level == CNT_W'(VECS[v].n), "R7 level", int'(rd_level), int'(VECS[v].n));
            chk(pin_n == !VECS[v].mode[1], "R8 interrupt", int'(pin_n), int'(!VECS[v].mode[1]));
            for (int i = 0; i < int'(VECS[v].n); i++) begin
                pop_one(d);
                chk(d == dat_log[(dat_base + i) % 256], "R7 order", int'(d),
                    int'(dat_log[(dat_base + i) % 256]));
            end
            chk(pin_n == 1'b1, "R8 clear on empty", int'(pin_n), 1);
        end
        chk(diff_log[0] == 1'b0, "R10 diff off", int'(diff_log[0]), 0);

        // R3 repeat fills FIFO then stalls
        start_cmd(2'b01, 2'b11, 2'b00, 3'd4, 1'b0, 1'b0);
        repeat (60) @(negedge clk);
        chk(n_req - req_base == 8, "R3 stall at full", n_req - req_base, 8);
        chk(chan_log[(req_base + 7) % 256] == 3'd4, "R3 channel", int'(chan_log[(req_base + 7) % 256]), 4);
        chk(rd_level == CNT_W'(8), "R3 level", int'(rd_level), 8);
        chk(pin_n == 1'b0, "R8 repeat interrupt", int'(pin_n), 0);
        pop_one(d);
        repeat (20) @(negedge clk);
        chk(n_req - req_base == 9, "R3 resume", n_req - req_base, 9);
        chk(rd_level == CNT_W'(8), "R3 refilled", int'(rd_level), 8);

        // R11 new command flushes and clears
        start_cmd(2'b00, 2'b00, 2'b00, 3'd1, 1'b0, 1'b0);
        chk(rd_level == '0, "R11 flush", int'(rd_level), 0);
        chk(pin_n == 1'b1, "R11 irq cleared", int'(pin_n), 1);
        repeat (20) @(negedge clk);
        chk(rd_level == CNT_W'(1), "R11 restart", int'(rd_level), 1);

        // R12 stray done ignored
        @(negedge clk); spur = 1'b1;
        @(negedge clk); spur = 1'b0;
        repeat (3) @(negedge clk);
        chk(rd_level == CNT_W'(1), "R12 stray done", int'(rd_level), 1);
        pop_one(d);
        pop_one(d);
        chk(rd_level == '0, "R7 pop on empty", int'(rd_level), 0);

        // R6 loop waits for empty FIFO
        start_cmd(2'b11, 2'b01, 2'b11, 3'd0, 1'b0, 1'b0);
        repeat (40) @(negedge clk);
        chk(n_req - req_base == 2, "R6 first pass", n_req - req_base, 2);
        chk(pin_n == 1'b0, "R8 loop interrupt", int'(pin_n), 0);
        pop_one(d);
        repeat (15) @(negedge clk);
        chk(n_req - req_base == 2, "R6 hold while not empty", n_req - req_base, 2);
        pop_one(d);
        chk(pin_n == 1'b1, "R8 clear", int'(pin_n), 1);
        repeat (20) @(negedge clk);
        chk(n_req - req_base == 4, "R6 second pass", n_req - req_base, 4);
        chk(chan_log[(req_base + 3) % 256] == 3'd2, "R4 loop channel", int'(chan_log[(req_base + 3) % 256]), 2);

        // R8 store and pop in the same cycle
        start_cmd(2'b10, 2'b01, 2'b11, 3'd0, 1'b0, 1'b0);
        @(posedge conv_done);
        @(posedge conv_done);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        chk(rd_level == CNT_W'(1), "R7 level after coincident pop", int'(rd_level), 1);
        chk(rd_data == dat_log[(dat_base + 1) % 256], "R7 survivor", int'(rd_data),
            int'(dat_log[(dat_base + 1) % 256]));
        repeat (10) @(negedge clk);
        chk(pin_n == 1'b1, "R8 no interrupt at position 0", int'(pin_n), 1);
        pop_one(d);

        // R9 busy strobe, R10 differential flag
        start_cmd(2'b00, 2'b00, 2'b00, 3'd3, 1'b1, 1'b1);
        chk(pin_n == 1'b1, "R9 high before accept", int'(pin_n), 1);
        @(negedge clk);
        chk(pin_n == 1'b0, "R9 low after accept", int'(pin_n), 0);
        @(posedge conv_done);
        chk(pin_n == 1'b0, "R9 low until store", int'(pin_n), 0);
        @(negedge clk);
        chk(pin_n == 1'b1, "R9 high after store", int'(pin_n), 1);
        chk(diff_log[req_base % 256] == 1'b1, "R10 diff on", int'(diff_log[req_base % 256]), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule